// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block turns a byte-wide memory array of 32K locations into a serial EEPROM that answers on a two-wire bus. It watches oversampled clock and data lines, finds bus START and STOP events, and answers only to its own device address. That address is a fixed 4-bit type code followed by three strap inputs. The block pulls the data line low to acknowledge and to send zeros. It never drives the line high.

A write command carries a two-byte word address followed by data bytes. The data bytes go into a 64-entry page stage, and the block touches the array only when the STOP arrives. It then scans the stage into the array and stays busy for a programming hold time. While busy it refuses its address. A read command streams bytes from an auto-incrementing pointer for as long as the master acknowledges. A dummy write followed by a repeated START sets the pointer for a random read. A write-protect input blocks every commit.

The array sits outside the block and uses a registered read. Read data must be valid on the clock cycle after the address. The pointer is always set well ahead of each byte load.

Top module: `smem_i2c_slave`

## Requirements
- R1: Before the first START the block ignores all SCL/SDA activity: a byte clocked in without a START gets no acknowledge, and while no transfer is active the pull-down stays released.
- R2: The first byte after a START is matched as bits 7..4 = 1010, bits 3..1 = strap_i[2:0], and bit 0 = direction (1 read, 0 write). A match is acknowledged. A mismatch gets no acknowledge, and every byte that follows is ignored until the next START.
- R3: In a write, the two bytes after the device byte form the word address, high byte first. Bit 7 of the high byte is discarded, which leaves a 15-bit pointer. The device byte, both address bytes and every data byte are acknowledged by pulling SDA low during the 9th clock.
- R4: Write data is held in the page stage. mem_we_o stays low until the STOP, and after the STOP each received byte is written once to its location.
- R5: Successive write data bytes increment only pointer bits 5..0. These bits wrap from 63 to 0 inside the same 64-byte page, and bytes outside the page are untouched.
- R6: The STOP commits only if at least one complete data byte was received. A write that carries only the address, or that ends part way through a data byte, leaves the array unchanged and busy_o low.
- R7: While wprot_i is high at the STOP, no commit happens: busy_o stays low and the array is unchanged, although bytes are still acknowledged.
- R8: busy_o rises after a committing STOP and stays high for 64 scan cycles plus HOLD_CYCLES. During that time the device address is not acknowledged. busy_o is low after reset.
- R9: In a read, the slave sends the byte at the pointer MSB first and then increments the pointer. It sends the next byte if the master acknowledges. After a master no-acknowledge it releases SDA and waits for STOP or START.
- R10: The read pointer wraps from 0x7FFF to 0x0000.
- R11: A repeated START at any point restarts the bit count and returns to address matching. A dummy write of the word address followed by a repeated START and a read device byte therefore reads from the address just set.
- R12: The pull-down output only changes while the synchronized SCL is low, and it is released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Address strap bits, matched against device byte bits 3..1 |
| wprot_i | input | 1 | High blocks every array write |
| busy_o | output | 1 | High while the page commit and its hold run |
| mem_addr_o | output | ADDR_W | Array address: commit address while busy, else read pointer |
| mem_rdata_i | input | 8 | Array read data, valid one cycle after the address |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |

## Verification
On every cycle the assertions check several properties. The pull-down never moves while SCL is high. An idle slave keeps the line released, and a START rearms address matching. A busy slave refuses its address, and write protection prevents a commit. The pointer wraps at the top of the array, and every busy period begins with a commit request. Whether the right bytes reach the right locations can only be shown by the bench scenarios. These cover bytes landing only after STOP, the page wrap, reads that cross the page and array ends, dummy-write random reads, and data left intact by protected, address-only and truncated writes.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WHI,
    PH_WLO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  // increment v, keeping only the low w bits
  function automatic logic [31:0] wrap_inc(logic [31:0] v, int unsigned w);
    return (v + 32'd1) & ((32'd1 << w) - 32'd1);
  endfunction

  // device byte bits 7..1 against type code and straps
  function automatic logic dev_match(logic [6:0] b, logic [2:0] strap);
    return (b[6:3] == DEV_TYPE) && (b[2:0] == strap);
  endfunction

endpackage

// File: rtl/smem_bus_sampler.sv
module smem_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  // R1: at most one bus event per cycle
  p_one_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_evt, stop_evt}));

endmodule

// File: rtl/smem_page_stage.sv
module smem_page_stage #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int HOLD_CYCLES = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     wr_i,
  input  logic [PAGE_W-1:0]        wr_idx_i,
  input  logic [7:0]               wr_data_i,
  input  logic                     go_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_i,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [7:0]               mem_wdata_o
);

  localparam int DEPTH  = 1 << PAGE_W;
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [1:0] {CM_IDLE, CM_SCAN, CM_HOLD} cm_t;

  logic [7:0]               stage_q [DEPTH];
  logic [DEPTH-1:0]         valid_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic [PAGE_W-1:0]        idx_q;
  logic [HOLD_W-1:0]        hold_q;
  cm_t                      cm_q;

  always_ff @(posedge clk) begin
    if (wr_i) stage_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      hold_q  <= '0;
      cm_q    <= CM_IDLE;
    end else begin
      if (clear_i)   valid_q <= '0;
      else if (wr_i) valid_q[wr_idx_i] <= 1'b1;
      case (cm_q)
        CM_IDLE: if (go_i) begin
          base_q <= base_i;
          idx_q  <= '0;
          cm_q   <= CM_SCAN;
        end
        CM_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == PAGE_W'(DEPTH - 1)) begin
            cm_q   <= CM_HOLD;
            hold_q <= HOLD_W'(HOLD_CYCLES);
          end
        end
        CM_HOLD: begin
          hold_q <= hold_q - 1'b1;
          if (hold_q == HOLD_W'(1)) cm_q <= CM_IDLE;
        end
        default: cm_q <= CM_IDLE;
      endcase
    end
  end

  assign busy_o      = (cm_q != CM_IDLE);
  assign mem_we_o    = (cm_q == CM_SCAN) && valid_q[idx_q];
  assign mem_addr_o  = {base_q, idx_q};
  assign mem_wdata_o = stage_q[idx_q];

  // R4: a busy period only follows a commit request
  p_busy_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(go_i));
  // R8: the stage is never refilled or restarted while committing
  p_no_fill_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i || clear_i || go_i) |-> !busy_o);

endmodule

// File: rtl/smem_i2c_slave.sv
module smem_i2c_slave
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        strap_i,
  input  logic              wprot_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o
);

  localparam int BASE_W = ADDR_W - PAGE_W;

  // bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  smem_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  phase_t            phase_q;
  logic [3:0]        cnt_q;
  logic [7:0]        rx_q, tx_q, hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rw_q, wr_cmd_q, have_data_q, pull_q, macked_q;

  // named internal events
  logic              byte_done, ack_end, addr_hit, read_load;
  logic              stage_wr, clear_stage, commit_go;
  logic [ADDR_W-1:0] ptr_inc, ptr_page_next, st_addr;

  assign byte_done   = scl_fall && (cnt_q == 4'd8);
  assign ack_end     = scl_fall && (cnt_q == 4'd9);
  assign addr_hit    = (phase_q == PH_DEV) && dev_match(rx_q[7:1], strap_i) && !busy_o;
  assign read_load   = ack_end && (((phase_q == PH_DEV) && rw_q) ||
                                   ((phase_q == PH_RDAT) && macked_q));
  assign stage_wr    = byte_done && (phase_q == PH_WDAT);
  assign clear_stage = byte_done && (phase_q == PH_WLO);
  assign commit_go   = stop_evt && wr_cmd_q && have_data_q && !wprot_i && !busy_o;

  assign ptr_inc       = ADDR_W'(wrap_inc(32'(ptr_q), ADDR_W));
  assign ptr_page_next = {ptr_q[ADDR_W-1:PAGE_W],
                          PAGE_W'(wrap_inc(32'(ptr_q[PAGE_W-1:0]), PAGE_W))};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      hi_q        <= '0;
      ptr_q       <= '0;
      rw_q        <= 1'b0;
      wr_cmd_q    <= 1'b0;
      have_data_q <= 1'b0;
      pull_q      <= 1'b0;
      macked_q    <= 1'b0;
    end else if (start_evt) begin
      phase_q     <= PH_DEV;
      cnt_q       <= '0;
      pull_q      <= 1'b0;
      wr_cmd_q    <= 1'b0;
      have_data_q <= 1'b0;
    end else if (stop_evt) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      pull_q      <= 1'b0;
      wr_cmd_q    <= 1'b0;
      have_data_q <= 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) begin
          rx_q  <= {rx_q[6:0], sda_s};
          cnt_q <= cnt_q + 4'd1;
        end else if (cnt_q == 4'd8) begin
          macked_q <= ~sda_s;
          cnt_q    <= 4'd9;
        end
      end else if (byte_done) begin
        case (phase_q)
          PH_DEV: begin
            if (addr_hit) begin
              pull_q   <= 1'b1;
              rw_q     <= rx_q[0];
              wr_cmd_q <= ~rx_q[0];
            end else begin
              phase_q <= PH_IDLE;
            end
          end
          PH_WHI: begin
            hi_q   <= rx_q;
            pull_q <= 1'b1;
          end
          PH_WLO: begin
            ptr_q  <= ADDR_W'({hi_q, rx_q});
            pull_q <= 1'b1;
          end
          PH_WDAT: begin
            ptr_q       <= ptr_page_next;
            have_data_q <= 1'b1;
            pull_q      <= 1'b1;
          end
          default: pull_q <= 1'b0;
        endcase
      end else if (ack_end) begin
        cnt_q  <= '0;
        pull_q <= 1'b0;
        case (phase_q)
          PH_DEV:  phase_q <= rw_q ? PH_RDAT : PH_WHI;
          PH_WHI:  phase_q <= PH_WLO;
          PH_WLO:  phase_q <= PH_WDAT;
          PH_RDAT: if (!macked_q) phase_q <= PH_IDLE;
          default: ;
        endcase
        if (read_load) begin
          tx_q   <= {mem_rdata_i[6:0], 1'b0};
          pull_q <= ~mem_rdata_i[7];
          ptr_q  <= ptr_inc;
        end
      end else if (scl_fall && (phase_q == PH_RDAT) && (cnt_q != 4'd0)) begin
        pull_q <= ~tx_q[7];
        tx_q   <= {tx_q[6:0], 1'b0};
      end
    end
  end

  smem_page_stage #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_stage),
    .wr_i        (stage_wr),
    .wr_idx_i    (ptr_q[PAGE_W-1:0]),
    .wr_data_i   (rx_q),
    .go_i        (commit_go),
    .base_i      (ptr_q[ADDR_W-1:PAGE_W]),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (st_addr),
    .mem_wdata_o (mem_wdata_o)
  );

  assign mem_addr_o = busy_o ? st_addr : ptr_q;
  assign sda_pull_o = pull_q;

  // R12: the line only moves while SCL is low
  p_pull_quiet_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));
  // R1 / R2: an inactive slave keeps the line released
  p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !sda_pull_o);
  // R8: address is refused during the commit
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase_q == PH_DEV) && busy_o) |=> !sda_pull_o);
  // R7: protected STOP starts no commit
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wprot_i) |=> !$rose(busy_o));
  // R11: START rearms address matching
  p_start_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ((phase_q == PH_DEV) && (cnt_q == 4'd0) && !sda_pull_o));
  // R10: pointer wraps at the top of the array
  p_ptr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (read_load && (ptr_q == '1)) |=> (ptr_q == '0));

  logic unused_bits;
  assign unused_bits = ^{BASE_W};

endmodule

// File: tb/smem_i2c_slave_bench.sv
module smem_i2c_slave_bench;

  localparam int PH = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wprot = 1'b0;
  logic sda_pull, busy, mem_we;
  logic [14:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00, mem_wdata;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  smem_i2c_slave u_smem_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(STRAP), .wprot_i(wprot), .busy_o(busy),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata)
  );

  logic [7:0] mem_m [int];
  logic [7:0] ref_m [int];
  logic [7:0] wbuf [16];
  int we_count = 0, checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [7:0] fill_val(int a);
    return 8'(a ^ (a >> 7) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] model_rd(int a);
    return mem_m.exists(a) ? mem_m[a] : fill_val(a);
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return ref_m.exists(a) ? ref_m[a] : fill_val(a);
  endfunction
  // page-wrapped target address of data byte k
  function automatic int page_addr(int a, int k);
    return (a & 32'h7FC0) | ((a + k) & 32'h3F);
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      mem_m[int'(mem_addr)] = mem_wdata;
      we_count++;
    end
    mem_rdata <= model_rd(int'(mem_addr));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clk_bit(input logic v, output logic s);
    sda_m = v; tick(PH);
    scl_m = 1'b1; tick(PH);
    s = sda_line;
    scl_m = 1'b0; tick(PH);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(nack, s);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(PH);
    scl_m = 1'b1; tick(PH);
    sda_m = 1'b0; tick(PH);
    scl_m = 1'b0; tick(PH);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(PH);
    scl_m = 1'b1; tick(PH);
    sda_m = 1'b1; tick(PH);
  endtask

  task automatic wait_idle;
    while (busy) tick(1);
    tick(2);
  endtask

  // full write; expect_commit false when protected
  task automatic do_write(int a, int n, logic [7:0] hi_extra);
    logic ack;
    bus_start;
    send_byte(DEV_W, ack);                      chk("R2", "dev W ack", ack, 1);
    send_byte(8'(a >> 8) | hi_extra, ack);      chk("R3", "hi addr ack", ack, 1);
    send_byte(8'(a), ack);                      chk("R3", "lo addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);                  chk("R3", "data ack", ack, 1);
    end
    bus_stop;
    if (!wprot)
      for (int k = 0; k < n; k++) ref_m[page_addr(a, k)] = wbuf[k];
  endtask

  // dummy write, repeated START, sequential read
  task automatic do_read(int a, int n);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(DEV_W, ack);        chk("R11", "dummy dev ack", ack, 1);
    send_byte(8'(a >> 8), ack);
    send_byte(8'(a), ack);        chk("R11", "dummy addr ack", ack, 1);
    bus_start;
    send_byte(DEV_R, ack);        chk("R11", "read dev ack after rep START", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      chk("R9", $sformatf("read byte @%0h", (a + k) & 32'h7FFF), d, ref_rd((a + k) & 32'h7FFF));
    end
    chk("R9", "released after master NACK", sda_pull, 0);
    bus_stop;
  endtask

  initial begin
    logic ack;
    int c0, a, n;
    tick(3);
    chk("R12", "pull after reset", sda_pull, 0);
    chk("R8", "busy after reset", busy, 0);
    rst_n = 1'b1;
    tick(4);

    // R1: byte without START
    scl_m = 1'b0; tick(PH);
    send_byte(DEV_W, ack);         chk("R1", "no START ack", ack, 0);
    bus_stop;

    // R2: wrong type code and wrong strap
    bus_start;
    send_byte(8'hBA, ack);         chk("R2", "wrong code ack", ack, 0);
    send_byte(8'h00, ack);         chk("R2", "after mismatch ack", ack, 0);
    bus_stop;
    bus_start;
    send_byte({4'b1010, 3'b001, 1'b0}, ack); chk("R2", "wrong strap ack", ack, 0);
    bus_stop;

    // R3/R4/R8: write 3 bytes at 0x1234, hi bit 7 set
    wbuf[0] = 8'hC3; wbuf[1] = 8'h00; wbuf[2] = 8'hA5;
    c0 = we_count;
    bus_start;
    send_byte(DEV_W, ack);  send_byte(8'h92, ack); send_byte(8'h34, ack);
    for (int k = 0; k < 3; k++) begin
      send_byte(wbuf[k], ack); chk("R3", "data ack", ack, 1);
    end
    chk("R4", "no write before STOP", we_count - c0, 0);
    bus_stop;
    for (int k = 0; k < 3; k++) ref_m[32'h1234 + k] = wbuf[k];
    chk("R8", "busy after commit STOP", busy, 1);
    bus_start;
    send_byte(DEV_W, ack);         chk("R8", "address NACK while busy", ack, 0);
    bus_stop;
    wait_idle;
    chk("R4", "one write per byte", we_count - c0, 3);
    chk("R3", "array @1234", model_rd(32'h1234), 8'hC3);
    chk("R3", "array @1236", model_rd(32'h1236), 8'hA5);
    do_read(32'h1233, 5);

    // R5: page wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(32'h0A3E, 4, 8'h00);
    wait_idle;
    chk("R5", "wrapped byte @0A00", model_rd(32'h0A00), 8'h33);
    chk("R5", "next page untouched @0A40", model_rd(32'h0A40), fill_val(32'h0A40));
    do_read(32'h0A3E, 3);
    do_read(32'h0A00, 2);

    // R6: address-only and truncated writes
    c0 = we_count;
    bus_start;
    send_byte(DEV_W, ack); send_byte(8'h05, ack); send_byte(8'h10, ack);
    bus_stop; tick(4);
    chk("R6", "address-only busy", busy, 0);
    bus_start;
    send_byte(DEV_W, ack); send_byte(8'h05, ack); send_byte(8'h10, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
    bus_stop; tick(4);
    chk("R6", "partial byte busy", busy, 0);
    chk("R6", "no array writes", we_count - c0, 0);

    // R7: write protect
    wprot = 1'b1;
    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    c0 = we_count;
    do_write(32'h0100, 2, 8'h00);
    tick(4);
    chk("R7", "busy under protect", busy, 0);
    chk("R7", "no array writes", we_count - c0, 0);
    wprot = 1'b0;
    do_read(32'h0100, 2);

    // R10: pointer wrap at top of array
    do_read(32'h7FFF, 2);

    // random writes and read-backs
    void'($urandom(32'h5EED));
    for (int t = 0; t < 6; t++) begin
      a = int'($urandom % 32768);
      n = 1 + int'($urandom % 8);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(a, n, 8'($urandom) & 8'h80);
      wait_idle;
      do_read(a, n);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule